// File: doc/BRIEF.md
# Deep Power-Down State Controller

This block manages the low-power state of a serial-memory slave that is reached over a four-wire serial link: chip select (active low), serial clock, data in and data out. It watches every selected frame. It recognises the sleep opcode 0xB9 and the wake-with-signature opcode 0xAB. From these it steps through four states: standby, entering sleep, asleep and waking. It also tells the rest of the device whether commands may be acted on.

The block puts the device to sleep only when a frame carries the sleep opcode and chip select is released right after the eighth bit. Once asleep, the device ignores every frame except the wake command. The wake command is the opcode 0xAB followed by 24 dummy address bits. After those 32 bits, the block drives an 8-bit identification byte out, MSB first, one bit on each falling serial-clock edge. Releasing chip select after a complete wake command starts a timed return to standby. The entry delay and the wake delay are counts of system clock cycles set by parameters.

All serial pins are sampled in the system clock domain. The serial clock must therefore run well below the system clock.

Top module: `pdc_deep_pd_ctrl`

## Requirements
- R1: After reset, or after any later reset, the block is in standby: `cmd_en` is 1, `low_power` is 0 and `spi_so_oe` is 0.
- R2: A frame whose first 8 bits are 0xB9 (MSB first), with chip select released after exactly 8 clock bits, lowers `cmd_en`. `low_power` then rises exactly `T_DP_CYC` system cycles after `cmd_en` fell.
- R3: In standby, a frame of 7 or 9 bits carrying 0xB9, or an 8-bit frame carrying any other opcode, leaves `cmd_en` at 1 and `low_power` at 0.
- R4: While asleep, any frame that is not a wake command of at least 32 bits leaves `low_power` at 1 and `cmd_en` at 0. This includes other opcodes, a repeated 0xB9 and a 0xAB frame of 31 bits.
- R5: In a wake frame sent while asleep, the identification byte appears on `spi_so` MSB first, with `spi_so_oe` at 1. Each bit is driven on a falling serial-clock edge, starting with the first falling edge after bit 32. `spi_so_oe` returns to 0 on the falling edge after the eighth bit, or when chip select is released.
- R6: Releasing chip select after 32 or more bits of a 0xAB frame while asleep lowers `low_power`. `cmd_en` then returns to 1 exactly `T_REL_CYC` system cycles after `low_power` fell.
- R7: `cmd_en` and `low_power` are never 1 at the same time, and `cmd_en` is 0 in every state other than standby.
- R8: In standby, a 0xAB frame never drives `spi_so_oe` high and does not change the state.
- R9: A frame sent during the wake delay, including 0xB9, is ignored. The return to standby keeps its timing, and `low_power` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_si | input | 1 | Serial data into the device |
| spi_so | output | 1 | Serial data out of the device (identification byte) |
| spi_so_oe | output | 1 | Output enable for `spi_so`; 0 means the pin is high impedance |
| cmd_en | output | 1 | 1 when the rest of the device may execute commands |
| low_power | output | 1 | 1 while fully in the sleep state |

## Verification
The assertions take for granted that the serial pins change slowly next to the system clock. Each serial-clock level and each data setup period is assumed to last at least a few system cycles, so the sampling chain catches every edge and the data-in value is already stable when a rising edge is detected. The stimulus keeps to this by holding every serial-clock half period for 8 system cycles. It changes data-in only while the serial clock is low, and it leaves 8 cycles of margin around each chip-select change. The assertions also assume that reset is held for at least one clock edge; the bench holds it for several.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        PWR_STBY  = 2'd0,
        PWR_ENTER = 2'd1,
        PWR_DEEP  = 2'd2,
        PWR_REL   = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic sel;
        logic sck;
        logic si;
    } pin_t;

    localparam logic [7:0] OP_SLEEP    = 8'hB9;
    localparam logic [7:0] OP_WAKE_SIG = 8'hAB;
    localparam int unsigned OPC_BITS   = 8;
    localparam int unsigned DUMMY_BITS = 24;
    localparam int unsigned HDR_BITS   = OPC_BITS + DUMMY_BITS;

endpackage

// File: rtl/pdc_spi_edge.sv
module pdc_spi_edge
    import pdc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic sel_o,
    output logic si_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic sel_start_o,
    output logic sel_end_o
);

    typedef struct packed {
        pin_t [STAGES-1:0] chain;
        logic              sel_prev;
        logic              sck_prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    pin_t        pin_in;
    pin_t        pin_last;

    assign pin_in   = '{sel: ~cs_n_i, sck: sck_i, si: si_i};
    assign pin_last = st_q.chain[STAGES-1];

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d          = st_q;
                st_d.chain[0] = pin_in;
                st_d.sel_prev = pin_last.sel;
                st_d.sck_prev = pin_last.sck;
            end
        end else begin : g_multi
            always_comb begin
                st_d          = st_q;
                st_d.chain    = {st_q.chain[STAGES-2:0], pin_in};
                st_d.sel_prev = pin_last.sel;
                st_d.sck_prev = pin_last.sck;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o       = pin_last.sel;
    assign si_o        = pin_last.si;
    assign sck_rise_o  =  pin_last.sck & ~st_q.sck_prev;
    assign sck_fall_o  = ~pin_last.sck &  st_q.sck_prev;
    assign sel_start_o =  pin_last.sel & ~st_q.sel_prev;
    assign sel_end_o   = ~pin_last.sel &  st_q.sel_prev;

endmodule

// File: rtl/pdc_frame_rx.sv
module pdc_frame_rx
    import pdc_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             si_i,
    input  logic             sck_rise_i,
    input  logic             sel_start_i,
    output logic [7:0]       opcode_o,
    output logic [CNT_W-1:0] bits_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(OPC_BITS - 1);

    typedef struct packed {
        logic [7:0]       shreg;
        logic [7:0]       opcode;
        logic [CNT_W-1:0] cnt;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [7:0] shifted;

    assign shifted = {st_q.shreg[6:0], si_i};

    always_comb begin
        st_d = st_q;
        if (sel_start_i) begin
            st_d.shreg  = '0;
            st_d.opcode = '0;
            st_d.cnt    = '0;
        end else if (sck_rise_i && sel_i) begin
            st_d.shreg = shifted;
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == OPC_LAST) st_d.opcode = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opcode_o = st_q.opcode;
    assign bits_o   = st_q.cnt;

endmodule

// File: rtl/pdc_sig_tx.sv
module pdc_sig_tx #(
    parameter int unsigned   DATA_W    = 8,
    parameter logic [DATA_W-1:0] SIGNATURE = 8'h29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sck_fall_i,
    input  logic sel_start_i,
    input  logic sel_end_i,
    input  logic armed_i,
    output logic so_o,
    output logic so_oe_o
);

    localparam int unsigned IDX_W = $clog2(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  sent;
        logic              so;
        logic              oe;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_start_i) begin
            st_d.shreg = SIGNATURE;
            st_d.sent  = '0;
            st_d.so    = 1'b0;
            st_d.oe    = 1'b0;
        end else if (sel_end_i) begin
            st_d.so = 1'b0;
            st_d.oe = 1'b0;
        end else if (sck_fall_i && sel_i) begin
            if (armed_i && st_q.sent != IDX_END) begin
                st_d.so    = st_q.shreg[DATA_W-1];
                st_d.oe    = 1'b1;
                st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                st_d.sent  = st_q.sent + 1'b1;
            end else begin
                st_d.so = 1'b0;
                st_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign so_o    = st_q.so;
    assign so_oe_o = st_q.oe;

    // R5
    oe_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe_o) |-> $past(armed_i && sel_i));

endmodule

// File: rtl/pdc_pwr_fsm.sv
module pdc_pwr_fsm
    import pdc_pkg::*;
#(
    parameter int unsigned T_DP_CYC  = 64,
    parameter int unsigned T_REL_CYC = 96,
    parameter int unsigned CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_end_i,
    input  logic [7:0]       opcode_i,
    input  logic [CNT_W-1:0] bits_i,
    output pwr_state_e       state_o,
    output logic             pd_active_o,
    output logic             cmd_en_o,
    output logic             low_power_o
);

    localparam int unsigned DLY_MAX = (T_DP_CYC > T_REL_CYC) ? T_DP_CYC : T_REL_CYC;
    localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);
    localparam logic [DLY_W-1:0] DP_LOAD  = DLY_W'(T_DP_CYC - 1);
    localparam logic [DLY_W-1:0] REL_LOAD = DLY_W'(T_REL_CYC - 1);
    localparam logic [CNT_W-1:0] BITS_OPC = CNT_W'(OPC_BITS);
    localparam logic [CNT_W-1:0] BITS_HDR = CNT_W'(HDR_BITS);

    typedef struct packed {
        pwr_state_e       state;
        logic [DLY_W-1:0] dly;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    logic sleep_req, wake_req;

    assign sleep_req = sel_end_i && opcode_i == OP_SLEEP && bits_i == BITS_OPC;
    assign wake_req  = sel_end_i && opcode_i == OP_WAKE_SIG && bits_i >= BITS_HDR;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            PWR_STBY: begin
                if (sleep_req) begin
                    st_d.state = PWR_ENTER;
                    st_d.dly   = DP_LOAD;
                end
            end
            PWR_ENTER: begin
                if (wake_req) begin
                    st_d.state = PWR_REL;
                    st_d.dly   = REL_LOAD;
                end else if (st_q.dly == '0) begin
                    st_d.state = PWR_DEEP;
                end else begin
                    st_d.dly = st_q.dly - 1'b1;
                end
            end
            PWR_DEEP: begin
                if (wake_req) begin
                    st_d.state = PWR_REL;
                    st_d.dly   = REL_LOAD;
                end
            end
            PWR_REL: begin
                if (st_q.dly == '0) st_d.state = PWR_STBY;
                else                st_d.dly   = st_q.dly - 1'b1;
            end
            default: st_d.state = PWR_STBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: PWR_STBY, dly: '0};
        else        st_q <= st_d;
    end

    assign state_o     = st_q.state;
    assign pd_active_o = (st_q.state == PWR_ENTER) || (st_q.state == PWR_DEEP);
    assign cmd_en_o    = (st_q.state == PWR_STBY);
    assign low_power_o = (st_q.state == PWR_DEEP);

    // R4
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PWR_DEEP && !sel_end_i) |=> st_q.state == PWR_DEEP);

    // R9
    rel_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PWR_REL) |=> (st_q.state == PWR_REL || st_q.state == PWR_STBY));

    // R3
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PWR_STBY && !sleep_req) |=> st_q.state == PWR_STBY);

endmodule

// File: rtl/pdc_deep_pd_ctrl.sv
module pdc_deep_pd_ctrl
    import pdc_pkg::*;
#(
    parameter int unsigned T_DP_CYC    = 64,
    parameter int unsigned T_REL_CYC   = 96,
    parameter logic [7:0]  SIGNATURE   = 8'h29,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe,
    output logic cmd_en,
    output logic low_power
);

    localparam int unsigned BIT_CNT_W = $clog2(HDR_BITS) + 1;
    localparam logic [BIT_CNT_W-1:0] HDR_CNT = BIT_CNT_W'(HDR_BITS);
    localparam logic [BIT_CNT_W-1:0] OPC_CNT = BIT_CNT_W'(OPC_BITS);

    logic                 sel, si_s, sck_rise, sck_fall, sel_start, sel_end;
    logic [7:0]           opcode;
    logic [BIT_CNT_W-1:0] rx_bits;
    pwr_state_e           pwr_state;
    logic                 pd_active;
    logic                 tx_armed;

    pdc_spi_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (spi_cs_n),
        .sck_i       (spi_sck),
        .si_i        (spi_si),
        .sel_o       (sel),
        .si_o        (si_s),
        .sck_rise_o  (sck_rise),
        .sck_fall_o  (sck_fall),
        .sel_start_o (sel_start),
        .sel_end_o   (sel_end)
    );

    pdc_frame_rx #(.CNT_W(BIT_CNT_W)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .si_i        (si_s),
        .sck_rise_i  (sck_rise),
        .sel_start_i (sel_start),
        .opcode_o    (opcode),
        .bits_o      (rx_bits)
    );

    pdc_pwr_fsm #(
        .T_DP_CYC  (T_DP_CYC),
        .T_REL_CYC (T_REL_CYC),
        .CNT_W     (BIT_CNT_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_end_i   (sel_end),
        .opcode_i    (opcode),
        .bits_i      (rx_bits),
        .state_o     (pwr_state),
        .pd_active_o (pd_active),
        .cmd_en_o    (cmd_en),
        .low_power_o (low_power)
    );

    assign tx_armed = pd_active && opcode == OP_WAKE_SIG && rx_bits >= HDR_CNT;

    pdc_sig_tx #(.DATA_W(8), .SIGNATURE(SIGNATURE)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .sck_fall_i  (sck_fall),
        .sel_start_i (sel_start),
        .sel_end_i   (sel_end),
        .armed_i     (tx_armed),
        .so_o        (spi_so),
        .so_oe_o     (spi_so_oe)
    );

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_en) |-> $past(sel_end && opcode == OP_SLEEP && rx_bits == OPC_CNT));

    // R6
    wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_power) |-> $past(sel_end && opcode == OP_WAKE_SIG && rx_bits >= HDR_CNT));

    // R8
    so_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_so_oe |-> (pwr_state == PWR_ENTER || pwr_state == PWR_DEEP));

    // R7
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_en && low_power));

endmodule

// File: tb/pdc_deep_pd_ctrl_tb.sv
module pdc_deep_pd_ctrl_tb_top;

    localparam int unsigned TDP  = 40;
    localparam int unsigned TREL = 400;
    localparam logic [7:0]  SIG  = 8'hA6;
    localparam int          HALF = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic cs_n, sck, si;
    logic so, so_oe, cmd_en, low_power;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    int t_cmd_fall = 0, t_lp_rise = 0, t_lp_fall = 0, t_cmd_rise = 0;
    int both_err = 0;
    bit prev_cmd = 1'b0, prev_lp = 1'b0;
    logic exp_q[$];
    string mon_tag = "R8";

    always #5 clk = ~clk;

    pdc_deep_pd_ctrl #(
        .T_DP_CYC    (TDP),
        .T_REL_CYC   (TREL),
        .SIGNATURE   (SIG),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (cs_n),
        .spi_sck   (sck),
        .spi_si    (si),
        .spi_so    (so),
        .spi_so_oe (so_oe),
        .cmd_en    (cmd_en),
        .low_power (low_power)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: clocks one frame and pushes the identification bits it expects.
    task automatic spi_frame(input logic [7:0] op, input int nbits, input bit expect_sig);
        if (expect_sig) begin
            for (int k = 0; k < nbits - 32 && k < 8; k++) exp_q.push_back(SIG[7-k]);
        end
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 8) ? op[7-i] : 1'b0;
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        si   = 1'b0;
        tick(10);
    endtask

    // Monitor: samples SO where the master would, pops and compares.
    always @(posedge sck) begin
        if (so_oe === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL %s: actual so_oe 1 expected 0 (unexpected drive)", mon_tag);
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk("R5 signature bit", 32'(so), 32'(e));
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cmd_en === 1'b1 && low_power === 1'b1) both_err++;
        if (rst_n === 1'b1) begin
            if (prev_cmd && !cmd_en)  t_cmd_fall = cyc;
            if (!prev_cmd && cmd_en)  t_cmd_rise = cyc;
            if (!prev_lp && low_power) t_lp_rise = cyc;
            if (prev_lp && !low_power) t_lp_fall = cyc;
        end
        prev_cmd = cmd_en;
        prev_lp  = low_power;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sck   = 1'b0;
        si    = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk("R1 cmd_en", 32'(cmd_en), 1);
        chk("R1 low_power", 32'(low_power), 0);
        chk("R1 so_oe", 32'(so_oe), 0);

        // R3 framing faults and wrong opcode
        spi_frame(8'hB9, 7, 0);
        chk("R3 7-bit sleep cmd_en", 32'(cmd_en), 1);
        spi_frame(8'hB9, 9, 0);
        chk("R3 9-bit sleep cmd_en", 32'(cmd_en), 1);
        spi_frame(8'h06, 8, 0);
        chk("R3 other opcode cmd_en", 32'(cmd_en), 1);
        chk("R3 low_power", 32'(low_power), 0);

        // R8 wake command in standby
        mon_tag = "R8";
        spi_frame(8'hAB, 41, 0);
        chk("R8 cmd_en", 32'(cmd_en), 1);
        chk("R8 low_power", 32'(low_power), 0);

        // R2 sleep entry timing
        spi_frame(8'hB9, 8, 0);
        chk("R7 cmd_en during entry", 32'(cmd_en), 0);
        tick(TDP + 10);
        chk("R2 low_power", 32'(low_power), 1);
        chk("R2 entry delay", 32'(t_lp_rise - t_cmd_fall), TDP);

        // R4 frames ignored while asleep
        mon_tag = "R4";
        spi_frame(8'h03, 32, 0);
        spi_frame(8'hB9, 8, 0);
        spi_frame(8'hAB, 31, 0);
        chk("R4 low_power", 32'(low_power), 1);
        chk("R4 cmd_en", 32'(cmd_en), 0);

        // R5/R6 full wake with signature, R9 frame during wake delay
        mon_tag = "R5";
        spi_frame(8'hAB, 41, 1);
        chk("R5 all bits delivered", 32'(exp_q.size()), 0);
        chk("R6 low_power", 32'(low_power), 0);
        chk("R7 cmd_en during wake", 32'(cmd_en), 0);
        spi_frame(8'hB9, 8, 0);
        chk("R9 cmd_en still low", 32'(cmd_en), 0);
        tick(TREL);
        chk("R6 wake delay", 32'(t_cmd_rise - t_lp_fall), TREL);
        chk("R9 cmd_en", 32'(cmd_en), 1);
        chk("R9 low_power", 32'(low_power), 0);

        // R5 partial read: chip select released after 3 identification bits
        spi_frame(8'hB9, 8, 0);
        tick(TDP + 10);
        spi_frame(8'hAB, 35, 1);
        chk("R5 partial bits delivered", 32'(exp_q.size()), 0);
        chk("R5 so_oe after release", 32'(so_oe), 0);
        tick(TREL + 10);
        chk("R6 cmd_en after partial read", 32'(cmd_en), 1);

        // R1 power cycle while asleep
        spi_frame(8'hB9, 8, 0);
        tick(TDP + 10);
        chk("R2 low_power again", 32'(low_power), 1);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R1 cmd_en after power cycle", 32'(cmd_en), 1);
        chk("R1 low_power after power cycle", 32'(low_power), 0);

        chk("R7 never both high", 32'(both_err), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule